// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a logical address, given as a segment number together with an offset, into a physical address. It uses a small table of segment descriptors. Each descriptor holds a base address, a limit, three permission flags (read, write, fetch) and a valid flag. Software loads a descriptor through a one-cycle write port. From then on, every request made with that segment number is translated through it.

For each request the block does two things at the same time: it adds the offset to the base, and it compares the offset against the limit and the permission flags. The outcome of the check decides what the response carries. A legal access returns the physical address. An illegal one returns a fault cause and no address. Requests and responses each use a valid/ready handshake, and the response is registered, so a translation takes one cycle.

Top module: `seg_xlat`

## Requirements
- R1: After reset, `rsp_valid` is low and every descriptor is invalid. A request made before any descriptor is written returns cause 2'b11.
- R2: A legal access returns cause 2'b00 (no fault). Its `rsp_paddr` equals the descriptor base plus the zero-extended offset, truncated to PA_W bits.
- R3: An access whose offset is greater than or equal to the descriptor limit returns cause 2'b01 (limit fault) with `rsp_paddr` zero. An offset of limit-1 is legal, and a limit of zero makes every offset fault.
- R4: Permission flags sit at bit 0 (read), bit 1 (write) and bit 2 (fetch). Access codes are 2'b00 read, 2'b01 write, 2'b10 fetch and 2'b11 reserved. An in-bounds access whose flag is clear, or any reserved-code access, returns cause 2'b10 (permission fault) with `rsp_paddr` zero.
- R5: When an access breaks both the limit and the permissions, the cause is the limit fault, 2'b01.
- R6: A segment number at or above NUM_SEG, or one that selects an invalid descriptor, returns cause 2'b11 (invalid segment). This cause takes priority over every other cause, and `rsp_paddr` is zero.
- R7: A request accepted at a clock edge (`req_valid` and `req_ready` both high) gives `rsp_valid` high, with its result, right after that edge.
- R8: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response holds its values unchanged.
- R9: A descriptor write is seen by requests accepted from the following edge on. A request accepted at the same edge as the write still sees the old descriptor.
- R10: Two descriptors may hold the same base. Equal offsets through either one then give the same physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | SEG_W | Descriptor index to write |
| cfg_base | input | PA_W | Base address to store |
| cfg_limit | input | OFF_W | Segment size in bytes |
| cfg_perm | input | 3 | Permission flags {fetch, write, read} |
| cfg_valid | input | 1 | Valid flag to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type code |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_paddr | output | PA_W | Physical address, zero on a fault |
| rsp_cause | output | 2 | Fault cause, 2'b00 when legal |

## Verification
Every result is due one edge after the request is accepted. The bench drives inputs on the falling edge and reads the response on the next falling edge, which falls after the accepting rising edge and before any later one. For back-pressure, the bench holds `rsp_ready` low for several cycles and samples once per cycle to check that the response stays the same and that `req_ready` stays low. For write visibility, a descriptor write and a request are driven in the same cycle. The expected result for that request is taken from the descriptor as it stood before the write.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_LIMIT   = 2'b01,
        CAUSE_PERM    = 2'b10,
        CAUSE_INVALID = 2'b11
    } cause_e;

    localparam int PERM_W = 3;
    localparam int PB_READ  = 0;
    localparam int PB_WRITE = 1;
    localparam int PB_FETCH = 2;

    function automatic logic perm_allows(input logic [PERM_W-1:0] p, input acc_e a);
        case (a)
            ACC_READ:  return p[PB_READ];
            ACC_WRITE: return p[PB_WRITE];
            ACC_FETCH: return p[PB_FETCH];
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlat_pkg::*;
#(
    parameter int SEG_W   = 3,
    parameter int NUM_SEG = 6,
    parameter int OFF_W   = 16,
    parameter int PA_W    = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEG_W-1:0]    wr_idx,
    input  logic [PA_W-1:0]     wr_base,
    input  logic [OFF_W-1:0]    wr_limit,
    input  logic [PERM_W-1:0]   wr_perm,
    input  logic                wr_valid,
    input  logic [SEG_W-1:0]    rd_idx,
    output logic [PA_W-1:0]     rd_base,
    output logic [OFF_W-1:0]    rd_limit,
    output logic [PERM_W-1:0]   rd_perm,
    output logic                rd_valid
);

    logic [PA_W-1:0]   ent_base  [NUM_SEG];
    logic [OFF_W-1:0]  ent_limit [NUM_SEG];
    logic [PERM_W-1:0] ent_perm  [NUM_SEG];
    logic              ent_vld   [NUM_SEG];

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_ent
        localparam logic [SEG_W-1:0] IDX = SEG_W'(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_vld[i]   <= 1'b0;
                ent_base[i]  <= '0;
                ent_limit[i] <= '0;
                ent_perm[i]  <= '0;
            end else if (wr_en && wr_idx == IDX) begin
                ent_vld[i]   <= wr_valid;
                ent_base[i]  <= wr_base;
                ent_limit[i] <= wr_limit;
                ent_perm[i]  <= wr_perm;
            end
        end
    end

    always_comb begin
        rd_base  = '0;
        rd_limit = '0;
        rd_perm  = '0;
        rd_valid = 1'b0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_idx == SEG_W'(i)) begin
                rd_base  = ent_base[i];
                rd_limit = ent_limit[i];
                rd_perm  = ent_perm[i];
                rd_valid = ent_vld[i];
            end
        end
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int PA_W  = 24
) (
    input  logic [PA_W-1:0]    base,
    input  logic [OFF_W-1:0]   limit,
    input  logic [PERM_W-1:0]  perm,
    input  logic               ent_ok,
    input  logic [OFF_W-1:0]   off,
    input  acc_e               acc,
    output logic [PA_W-1:0]    paddr,
    output cause_e             cause
);

    logic [PA_W-1:0] sum;
    logic            in_bounds;
    logic            allowed;

    assign sum       = base + PA_W'(off);
    assign in_bounds = off < limit;
    assign allowed   = perm_allows(perm, acc);

    always_comb begin
        if (!ent_ok)          cause = CAUSE_INVALID;
        else if (!in_bounds)  cause = CAUSE_LIMIT;
        else if (!allowed)    cause = CAUSE_PERM;
        else                  cause = CAUSE_NONE;
        paddr = (cause == CAUSE_NONE) ? sum : '0;
    end

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter int SEG_W   = 3,
    parameter int NUM_SEG = 6,
    parameter int OFF_W   = 16,
    parameter int PA_W    = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [SEG_W-1:0]   cfg_idx,
    input  logic [PA_W-1:0]    cfg_base,
    input  logic [OFF_W-1:0]   cfg_limit,
    input  logic [2:0]         cfg_perm,
    input  logic               cfg_valid,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SEG_W-1:0]   req_seg,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [1:0]         req_acc,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_cause
);

    localparam logic [SEG_W:0] SEG_LIM = (SEG_W+1)'(NUM_SEG);

    logic [PA_W-1:0]   t_base;
    logic [OFF_W-1:0]  t_limit;
    logic [PERM_W-1:0] t_perm;
    logic              t_valid;
    logic              seg_in_range;
    logic [PA_W-1:0]   x_paddr;
    cause_e            x_cause;
    logic              accept;

    seg_table #(
        .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .OFF_W(OFF_W), .PA_W(PA_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_base  (cfg_base),
        .wr_limit (cfg_limit),
        .wr_perm  (cfg_perm),
        .wr_valid (cfg_valid),
        .rd_idx   (req_seg),
        .rd_base  (t_base),
        .rd_limit (t_limit),
        .rd_perm  (t_perm),
        .rd_valid (t_valid)
    );

    assign seg_in_range = {1'b0, req_seg} < SEG_LIM;

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .base   (t_base),
        .limit  (t_limit),
        .perm   (t_perm),
        .ent_ok (t_valid && seg_in_range),
        .off    (req_off),
        .acc    (acc_e'(req_acc)),
        .paddr  (x_paddr),
        .cause  (x_cause)
    );

    assign req_ready = !rsp_valid || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_cause <= CAUSE_NONE;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= x_paddr;
            rsp_cause <= x_cause;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
    parameter int SEG_W   = 3,
    parameter int NUM_SEG = 6,
    parameter int OFF_W   = 16,
    parameter int PA_W    = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic [SEG_W-1:0]   cfg_idx,
    input logic [PA_W-1:0]    cfg_base,
    input logic [OFF_W-1:0]   cfg_limit,
    input logic [2:0]         cfg_perm,
    input logic               cfg_valid,
    input logic               req_valid,
    input logic               req_ready,
    input logic [SEG_W-1:0]   req_seg,
    input logic [OFF_W-1:0]   req_off,
    input logic [1:0]         req_acc,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic [1:0]         rsp_cause
);

    logic [PA_W-1:0]  sh_base  [NUM_SEG];
    logic [OFF_W-1:0] sh_limit [NUM_SEG];
    logic             sh_vld   [NUM_SEG];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rst) begin
                sh_vld[i]   <= 1'b0;
                sh_base[i]  <= '0;
                sh_limit[i] <= '0;
            end else if (cfg_we && int'(cfg_idx) == i) begin
                sh_vld[i]   <= cfg_valid;
                sh_base[i]  <= cfg_base;
                sh_limit[i] <= cfg_limit;
            end
        end
    end

    logic            acc_now;
    logic            live;
    logic            over;
    logic [PA_W-1:0] want_pa;

    always_comb begin
        live    = 1'b0;
        over    = 1'b0;
        want_pa = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (int'(req_seg) == i) begin
                live    = sh_vld[i];
                over    = req_off >= sh_limit[i];
                want_pa = sh_base[i] + PA_W'(req_off);
            end
        end
    end

    assign acc_now = req_valid && req_ready;

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !rsp_valid); // R1

    AST_READY_RULE: assert property (@(posedge clk) disable iff (rst)
        req_ready == (!rsp_valid || rsp_ready)); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause)); // R8

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        acc_now |=> rsp_valid); // R7

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_cause != 2'b00 |-> rsp_paddr == '0); // R3

    AST_DEAD_SEGMENT: assert property (@(posedge clk) disable iff (rst)
        acc_now && !live |=> rsp_cause == 2'b11); // R6

    AST_LIMIT_WINS: assert property (@(posedge clk) disable iff (rst)
        acc_now && live && over |=> rsp_cause == 2'b01); // R5

    AST_SUM_OK: assert property (@(posedge clk) disable iff (rst)
        acc_now && live && !over |=> rsp_cause == 2'b10 || rsp_paddr == $past(want_pa)); // R2

endmodule

bind seg_xlat seg_xlat_chk #(
    .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .OFF_W(OFF_W), .PA_W(PA_W)
) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_perm(cfg_perm), .cfg_valid(cfg_valid),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
    .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause)
);

// File: tb/tb_seg_xlat.sv
module tb_seg_xlat;

    localparam int SEG_W = 3, NUM_SEG = 6, OFF_W = 16, PA_W = 24;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_we = 0, cfg_valid = 0;
    logic [SEG_W-1:0] cfg_idx = '0;
    logic [PA_W-1:0]  cfg_base = '0;
    logic [OFF_W-1:0] cfg_limit = '0;
    logic [2:0]       cfg_perm = '0;
    logic req_valid = 0, rsp_ready = 1;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0]       req_acc = '0;
    logic req_ready, rsp_valid;
    logic [PA_W-1:0] rsp_paddr;
    logic [1:0]      rsp_cause;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [PA_W-1:0]  m_base  [NUM_SEG];
    logic [OFF_W-1:0] m_limit [NUM_SEG];
    logic [2:0]       m_perm  [NUM_SEG];
    logic             m_vld   [NUM_SEG];

    always #2.5 clk = ~clk;

    seg_xlat #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .OFF_W(OFF_W), .PA_W(PA_W)) dut (.*);

    function automatic void expect_of(input int seg, input logic [OFF_W-1:0] off,
                                      input logic [1:0] acc,
                                      output logic [PA_W-1:0] pa, output logic [1:0] cs);
        logic ok;
        pa = '0;
        if (seg >= NUM_SEG || !m_vld[seg]) begin cs = 2'b11; return; end
        if (off >= m_limit[seg]) begin cs = 2'b01; return; end
        case (acc)
            2'b00: ok = m_perm[seg][0];
            2'b01: ok = m_perm[seg][1];
            2'b10: ok = m_perm[seg][2];
            default: ok = 1'b0;
        endcase
        if (!ok) begin cs = 2'b10; return; end
        cs = 2'b00;
        pa = m_base[seg] + PA_W'(off);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic [PA_W-1:0] b,
                             input logic [OFF_W-1:0] l, input logic [2:0] p, input logic v);
        @(negedge clk);
        cfg_we = 1; cfg_idx = SEG_W'(idx); cfg_base = b; cfg_limit = l;
        cfg_perm = p; cfg_valid = v;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0;
        if (idx < NUM_SEG) begin
            m_base[idx] = b; m_limit[idx] = l; m_perm[idx] = p; m_vld[idx] = v;
        end
    endtask

    task automatic do_req(input string req, input int seg, input logic [OFF_W-1:0] off,
                          input logic [1:0] acc);
        logic [PA_W-1:0] epa;
        logic [1:0] ecs;
        expect_of(seg, off, acc, epa, ecs);
        @(negedge clk);
        req_valid = 1; req_seg = SEG_W'(seg); req_off = off; req_acc = acc;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " cause"}, 32'(rsp_cause), 32'(ecs));
        check({req, " paddr"}, 32'(rsp_paddr), 32'(epa));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [PA_W-1:0] held_pa;
        logic [1:0] held_cs, epa_cs;
        logic [PA_W-1:0] epa;
        void'($urandom(32'h5E6A11));
        for (int i = 0; i < NUM_SEG; i++) begin
            m_vld[i] = 0; m_base[i] = '0; m_limit[i] = '0; m_perm[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R1 req_ready after reset", 32'(req_ready), 32'd1);
        do_req("R1 empty table", 0, 16'h0000, 2'b00);

        cfg_write(0, 24'h100000, 16'h0400, 3'b101, 1);   // code: read+fetch
        cfg_write(1, 24'h200000, 16'h1000, 3'b011, 1);   // data: read+write
        cfg_write(2, 24'hFFFF00, 16'h0800, 3'b111, 1);   // wraps past top
        cfg_write(3, 24'h200000, 16'h1000, 3'b001, 1);   // alias of 1, read only
        cfg_write(4, 24'h300000, 16'h0000, 3'b111, 1);   // zero limit
        cfg_write(5, 24'h400000, 16'hFFFF, 3'b111, 0);   // invalid

        do_req("R2 data read",      1, 16'h0123, 2'b00);
        do_req("R2 data write",     1, 16'h0FFF, 2'b01);
        do_req("R2 code fetch",     0, 16'h03FF, 2'b10);
        do_req("R2 wrap sum",       2, 16'h0200, 2'b00);
        do_req("R3 offset=limit",   0, 16'h0400, 2'b00);
        do_req("R3 zero limit",     4, 16'h0000, 2'b00);
        do_req("R4 write to code",  0, 16'h0010, 2'b01);
        do_req("R4 fetch from data",1, 16'h0010, 2'b10);
        do_req("R4 reserved acc",   2, 16'h0010, 2'b11);
        do_req("R5 limit over perm",0, 16'h0500, 2'b01);
        do_req("R6 invalid entry",  5, 16'h0000, 2'b00);
        do_req("R6 seg beyond table", 7, 16'h0000, 2'b00);
        do_req("R10 alias a",       1, 16'h0040, 2'b00);
        do_req("R10 alias b",       3, 16'h0040, 2'b00);
        check("R10 alias equal", 32'(rsp_paddr), 32'h200040);

        // R9: write and request in the same cycle; request sees old entry
        expect_of(0, 16'h0500, 2'b00, epa, epa_cs);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 0; cfg_base = 24'h500000; cfg_limit = 16'h2000;
        cfg_perm = 3'b111; cfg_valid = 1;
        req_valid = 1; req_seg = 0; req_off = 16'h0500; req_acc = 2'b00;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        m_base[0] = 24'h500000; m_limit[0] = 16'h2000; m_perm[0] = 3'b111; m_vld[0] = 1;
        check("R9 same-edge old cause", 32'(rsp_cause), 32'(epa_cs));
        do_req("R9 next request new entry", 0, 16'h0500, 2'b01);

        // R7/R8 back-pressure
        @(negedge clk);
        rsp_ready = 0;
        req_valid = 1; req_seg = 1; req_off = 16'h0020; req_acc = 2'b00;
        @(posedge clk);
        @(negedge clk);
        check("R7 response next cycle", 32'(rsp_valid), 32'd1);
        held_pa = rsp_paddr; held_cs = rsp_cause;
        req_seg = 0; req_off = 16'h0030; req_acc = 2'b10;
        for (int k = 0; k < 3; k++) begin
            check("R8 ready low when stalled", 32'(req_ready), 32'd0);
            check("R8 paddr held", 32'(rsp_paddr), 32'(held_pa));
            check("R8 cause held", 32'(rsp_cause), 32'(held_cs));
            @(negedge clk);
        end
        check("R8 held value", 32'(held_pa), 32'h200020);
        rsp_ready = 1;
        @(negedge clk);
        check("R8 ready follows rsp_ready", 32'(req_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        check("R8 second response paddr", 32'(rsp_paddr), 32'h500030);
        check("R8 second response cause", 32'(rsp_cause), 32'd0);
        @(negedge clk);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int seg;
            logic [OFF_W-1:0] off;
            logic [1:0] acc;
            if (n % 25 == 0)
                cfg_write($urandom_range(0, NUM_SEG - 1), PA_W'($urandom),
                          OFF_W'($urandom_range(0, 16'h3000)), 3'($urandom), ($urandom_range(0, 5) != 0));
            seg = $urandom_range(0, 7);
            acc = 2'($urandom);
            if (seg < NUM_SEG && $urandom_range(0, 1) == 1)
                off = m_limit[seg] + OFF_W'($urandom_range(0, 2)) - OFF_W'(1);
            else
                off = OFF_W'($urandom_range(0, 16'h3FFF));
            do_req("R2-R6 random", seg, off, acc);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule